// File: doc/BRIEF.md
# Exception entry controller

This block performs the register side of taking an exception in a processor core. When the pipeline raises a general exception or a debug exception, the block captures the program counter, the cause code, an optional faulting virtual address and the current status word. In the same clock edge it writes the matching save registers, produces the new status word and selects the vector the fetch unit should jump to.

The block has five states, and each state also names the vector just taken. IDLE means nothing was taken on the last edge. USER and KERNEL mean a first-level general exception was taken from user or kernel mode. DOUBLE means a general exception arrived while the exception-mode flag was already set. DEBUG means a debug exception was accepted.

From any state the next state depends only on that cycle's requests. An accepted debug request moves the block to DEBUG. Otherwise a general request moves it to DOUBLE, USER or KERNEL, chosen by the status word. With no request, or only a debug request that is masked, the block returns to IDLE. Each non-IDLE state therefore lasts exactly one cycle unless another request follows at once.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset every save register, the status output and the vector identifier are zero, and the vector strobe is low.
- R2: A general exception taken while the exception-mode flag (status bit 4) is clear writes the PC to the first-level exception PC. The vector code is 1 (user) when the user-mode flag (status bit 5) is set and 2 (kernel) otherwise.
- R3: A general exception taken while the exception-mode flag is set selects vector code 3 (double). With HAS_DEPC=1 the PC goes to the double-exception PC register and the first-level exception PC is left unchanged. With HAS_DEPC=0 the PC goes to the first-level exception PC.
- R4: Every general exception writes the cause code to the exception-cause register. The status output becomes the input status word with bit 4 set.
- R5: A general exception with the address-valid input high writes the address to the exception-address register. With the address-valid input low that register keeps its value.
- R6: A debug request is accepted only when the current interrupt level is strictly below DEBUG_LEVEL. A masked debug request on its own changes no register and raises no strobe.
- R7: An accepted debug exception writes the cause to the debug-cause register, the PC to the debug-level PC register and the input status word to the debug-level status save register.
- R8: An accepted debug exception sets the status output to the input status word with bits 3:0 replaced by DEBUG_LEVEL and bit 4 set. It selects vector code 4.
- R9: The vector strobe is high for exactly the one cycle that follows the clock edge on which an exception is taken, and the vector identifier is valid with it. When the strobe is low the identifier is 0.
- R10: When a general and an accepted debug request arrive in the same cycle, only the debug exception is taken and the general save registers keep their values. When the debug request is masked, the general exception is taken instead.
- R11: On a cycle with no request, every save register and the status output keep their values, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_gen_i | input | 1 | General exception request pulse |
| raise_dbg_i | input | 1 | Debug exception request pulse |
| pc_i | input | AW | PC of the excepting instruction |
| cause_i | input | CW | Cause code |
| vaddr_i | input | AW | Faulting virtual address |
| vaddr_vld_i | input | 1 | Address input is meaningful for this exception |
| ps_i | input | PSW | Current status word |
| cur_level_i | input | 4 | Current interrupt level |
| ps_o | output | PSW | Updated status word |
| epc1_o | output | AW | First-level exception PC |
| depc_o | output | AW | Double-exception PC (zero when HAS_DEPC=0) |
| exccause_o | output | CW | Exception cause register |
| excvaddr_o | output | AW | Exception virtual-address register |
| dbgcause_o | output | CW | Debug cause register |
| dbg_epc_o | output | AW | PC saved at the debug level |
| dbg_eps_o | output | PSW | Status word saved at the debug level |
| vec_valid_o | output | 1 | One-cycle strobe: an exception was taken |
| vec_id_o | output | 3 | Vector code: 1 user, 2 kernel, 3 double, 4 debug |

## Verification
The bench builds two copies with a 16-bit address, an 8-bit status word and DEBUG_LEVEL=3: one with HAS_DEPC=1 and one with HAS_DEPC=0. Both routes for a double exception are therefore compared on the same stimulus. The small status word lets the bench sweep every combination of exception-mode flag, user-mode flag and address-valid input. Every interrupt level from 0 to 15 is driven against the debug level of 3, which covers both sides of the masking boundary, alone and together with a general request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    // status word field positions
    localparam int PS_LVL_LSB  = 0;
    localparam int PS_LVL_W    = 4;
    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;

    // state encoding doubles as the vector code
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_USER   = 3'd1,
        ST_KERNEL = 3'd2,
        ST_DOUBLE = 3'd3,
        ST_DEBUG  = 3'd4
    } exc_state_e;
endpackage

// File: rtl/exc_entry_arbiter.sv
module exc_entry_arbiter
    import exc_entry_pkg::*;
#(
    parameter int DEBUG_LEVEL = 6
) (
    input  logic                raise_gen,
    input  logic                raise_dbg,
    input  logic [PS_LVL_W-1:0] cur_level,
    input  logic                excm,
    input  logic                um,
    output exc_state_e          nxt
);
    localparam logic [PS_LVL_W-1:0] DBG_LVL = PS_LVL_W'(DEBUG_LEVEL);

    logic dbg_ok;

    always_comb begin
        dbg_ok = raise_dbg && (cur_level < DBG_LVL);
        if (dbg_ok) begin
            nxt = ST_DEBUG;
        end else if (raise_gen) begin
            if (excm)    nxt = ST_DOUBLE;
            else if (um) nxt = ST_USER;
            else         nxt = ST_KERNEL;
        end else begin
            nxt = ST_IDLE;
        end
    end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
    import exc_entry_pkg::*;
#(
    parameter int AW          = 32,
    parameter int CW          = 6,
    parameter int PSW         = 16,
    parameter int DEBUG_LEVEL = 6,
    parameter bit HAS_DEPC    = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  exc_state_e     take,
    input  logic [AW-1:0]  pc_i,
    input  logic [CW-1:0]  cause_i,
    input  logic [AW-1:0]  vaddr_i,
    input  logic           vaddr_vld_i,
    input  logic [PSW-1:0] ps_i,
    output logic [PSW-1:0] ps_o,
    output logic [AW-1:0]  epc1_o,
    output logic [AW-1:0]  depc_o,
    output logic [CW-1:0]  exccause_o,
    output logic [AW-1:0]  excvaddr_o,
    output logic [CW-1:0]  dbgcause_o,
    output logic [AW-1:0]  dbg_epc_o,
    output logic [PSW-1:0] dbg_eps_o
);
    localparam logic DOUBLE_TO_EPC1 = (HAS_DEPC == 1'b0);

    logic [PSW-1:0] ps_gen;
    logic [PSW-1:0] ps_dbg;
    logic           is_gen;
    logic           epc1_wr;

    always_comb begin
        ps_gen = ps_i;
        ps_gen[PS_EXCM_BIT] = 1'b1;
        ps_dbg = ps_i;
        ps_dbg[PS_LVL_LSB +: PS_LVL_W] = PS_LVL_W'(DEBUG_LEVEL);
        ps_dbg[PS_EXCM_BIT] = 1'b1;
        is_gen  = (take == ST_USER) || (take == ST_KERNEL) || (take == ST_DOUBLE);
        epc1_wr = (take == ST_USER) || (take == ST_KERNEL) ||
                  ((take == ST_DOUBLE) && DOUBLE_TO_EPC1);
    end

    // general registers and the status output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_o       <= '0;
            epc1_o     <= '0;
            exccause_o <= '0;
            excvaddr_o <= '0;
        end else begin
            if (epc1_wr) epc1_o <= pc_i;
            if (is_gen) begin
                exccause_o <= cause_i;
                ps_o       <= ps_gen;
                if (vaddr_vld_i) excvaddr_o <= vaddr_i;
            end else if (take == ST_DEBUG) begin
                ps_o <= ps_dbg;
            end
        end
    end

    // debug-level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbgcause_o <= '0;
            dbg_epc_o  <= '0;
            dbg_eps_o  <= '0;
        end else if (take == ST_DEBUG) begin
            dbgcause_o <= cause_i;
            dbg_epc_o  <= pc_i;
            dbg_eps_o  <= ps_i;
        end
    end

    // optional double-exception PC
    generate
        if (HAS_DEPC) begin : g_depc
            logic [AW-1:0] depc_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                depc_q <= '0;
                else if (take == ST_DOUBLE) depc_q <= pc_i;
            end
            assign depc_o = depc_q;
        end else begin : g_no_depc
            assign depc_o = '0;
        end
    endgenerate
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int AW          = 32,
    parameter int CW          = 6,
    parameter int PSW         = 16,
    parameter int DEBUG_LEVEL = 6,
    parameter bit HAS_DEPC    = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raise_gen_i,
    input  logic                raise_dbg_i,
    input  logic [AW-1:0]       pc_i,
    input  logic [CW-1:0]       cause_i,
    input  logic [AW-1:0]       vaddr_i,
    input  logic                vaddr_vld_i,
    input  logic [PSW-1:0]      ps_i,
    input  logic [PS_LVL_W-1:0] cur_level_i,
    output logic [PSW-1:0]      ps_o,
    output logic [AW-1:0]       epc1_o,
    output logic [AW-1:0]       depc_o,
    output logic [CW-1:0]       exccause_o,
    output logic [AW-1:0]       excvaddr_o,
    output logic [CW-1:0]       dbgcause_o,
    output logic [AW-1:0]       dbg_epc_o,
    output logic [PSW-1:0]      dbg_eps_o,
    output logic                vec_valid_o,
    output logic [2:0]          vec_id_o
);
    exc_state_e state;
    exc_state_e nxt;

    exc_entry_arbiter #(
        .DEBUG_LEVEL (DEBUG_LEVEL)
    ) u_arb (
        .raise_gen (raise_gen_i),
        .raise_dbg (raise_dbg_i),
        .cur_level (cur_level_i),
        .excm      (ps_i[PS_EXCM_BIT]),
        .um        (ps_i[PS_UM_BIT]),
        .nxt       (nxt)
    );

    exc_save_bank #(
        .AW          (AW),
        .CW          (CW),
        .PSW         (PSW),
        .DEBUG_LEVEL (DEBUG_LEVEL),
        .HAS_DEPC    (HAS_DEPC)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (nxt),
        .pc_i        (pc_i),
        .cause_i     (cause_i),
        .vaddr_i     (vaddr_i),
        .vaddr_vld_i (vaddr_vld_i),
        .ps_i        (ps_i),
        .ps_o        (ps_o),
        .epc1_o      (epc1_o),
        .depc_o      (depc_o),
        .exccause_o  (exccause_o),
        .excvaddr_o  (excvaddr_o),
        .dbgcause_o  (dbgcause_o),
        .dbg_epc_o   (dbg_epc_o),
        .dbg_eps_o   (dbg_eps_o)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs from state
    always_comb begin
        vec_valid_o = 1'b1;
        vec_id_o    = 3'd0;
        unique case (state)
            ST_IDLE:   vec_valid_o = 1'b0;
            ST_USER:   vec_id_o = 3'd1;
            ST_KERNEL: vec_id_o = 3'd2;
            ST_DOUBLE: vec_id_o = 3'd3;
            ST_DEBUG:  vec_id_o = 3'd4;
            default:   vec_valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int AW          = 32,
    parameter int CW          = 6,
    parameter int PSW         = 16,
    parameter int DEBUG_LEVEL = 6,
    parameter bit HAS_DEPC    = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           raise_gen_i,
    input logic           raise_dbg_i,
    input logic [3:0]     cur_level_i,
    input logic [PSW-1:0] ps_o,
    input logic [AW-1:0]  epc1_o,
    input logic [CW-1:0]  exccause_o,
    input logic           vec_valid_o,
    input logic [2:0]     vec_id_o
);
    localparam logic [3:0] DL = 4'(DEBUG_LEVEL);

    a_r9_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(raise_gen_i || raise_dbg_i));

    a_r9_idle_id: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> (vec_id_o == 3'd0));

    a_r6_debug_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_id_o == 3'd4) |-> ($past(cur_level_i) < DL));

    a_r10_debug_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raise_dbg_i) && ($past(cur_level_i) < DL)) |-> (vec_id_o == 3'd4));

    a_r8_debug_ps: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_id_o == 3'd4) |-> (ps_o[4] && (ps_o[3:0] == DL)));

    a_r4_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> ps_o[4]);

    a_r3_epc1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((vec_id_o == 3'd3) && HAS_DEPC) |-> $stable(epc1_o));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(raise_gen_i || raise_dbg_i) |-> ($stable(epc1_o) && $stable(exccause_o) && $stable(ps_o)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .AW          (AW),
    .CW          (CW),
    .PSW         (PSW),
    .DEBUG_LEVEL (DEBUG_LEVEL),
    .HAS_DEPC    (HAS_DEPC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_gen_i (raise_gen_i),
    .raise_dbg_i (raise_dbg_i),
    .cur_level_i (cur_level_i),
    .ps_o        (ps_o),
    .epc1_o      (epc1_o),
    .exccause_o  (exccause_o),
    .vec_valid_o (vec_valid_o),
    .vec_id_o    (vec_id_o)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int CW  = 6;
    localparam int PSW = 8;
    localparam int DL  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raise_gen = 1'b0, raise_dbg = 1'b0, vv = 1'b0;
    logic [AW-1:0] pc = '0, va = '0;
    logic [CW-1:0] cause = '0;
    logic [PSW-1:0] ps = '0;
    logic [3:0] lvl = '0;

    logic [PSW-1:0] ps_o [2];
    logic [AW-1:0]  epc1 [2], depc [2], excva [2], depc_dbg [2];
    logic [CW-1:0]  ecause [2], dcause [2];
    logic [PSW-1:0] deps [2];
    logic           vvalid [2];
    logic [2:0]     vid [2];

    // expected model
    logic [PSW-1:0] m_ps [2];
    logic [AW-1:0]  m_epc1 [2], m_depc [2], m_excva [2], m_depc_dbg [2];
    logic [CW-1:0]  m_ecause [2], m_dcause [2];
    logic [PSW-1:0] m_deps [2];
    logic           m_vvalid;
    logic [2:0]     m_vid [2];

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl #(.AW(AW), .CW(CW), .PSW(PSW), .DEBUG_LEVEL(DL), .HAS_DEPC(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .raise_gen_i(raise_gen), .raise_dbg_i(raise_dbg),
        .pc_i(pc), .cause_i(cause), .vaddr_i(va), .vaddr_vld_i(vv), .ps_i(ps),
        .cur_level_i(lvl), .ps_o(ps_o[0]), .epc1_o(epc1[0]), .depc_o(depc[0]),
        .exccause_o(ecause[0]), .excvaddr_o(excva[0]), .dbgcause_o(dcause[0]),
        .dbg_epc_o(depc_dbg[0]), .dbg_eps_o(deps[0]), .vec_valid_o(vvalid[0]),
        .vec_id_o(vid[0]));

    exc_entry_ctrl #(.AW(AW), .CW(CW), .PSW(PSW), .DEBUG_LEVEL(DL), .HAS_DEPC(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .raise_gen_i(raise_gen), .raise_dbg_i(raise_dbg),
        .pc_i(pc), .cause_i(cause), .vaddr_i(va), .vaddr_vld_i(vv), .ps_i(ps),
        .cur_level_i(lvl), .ps_o(ps_o[1]), .epc1_o(epc1[1]), .depc_o(depc[1]),
        .exccause_o(ecause[1]), .excvaddr_o(excva[1]), .dbgcause_o(dcause[1]),
        .dbg_epc_o(depc_dbg[1]), .dbg_eps_o(deps[1]), .vec_valid_o(vvalid[1]),
        .vec_id_o(vid[1]));

    task automatic chk(input string tag, input int k, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst%0d: actual %h expected %h", tag, k, act, exp);
        end
    endtask

    task automatic check_all(input string scen);
        for (int k = 0; k < 2; k++) begin
            chk({scen, " R2 epc1"},      k, 32'(epc1[k]),     32'(m_epc1[k]));
            chk({scen, " R3 depc"},      k, 32'(depc[k]),     32'(m_depc[k]));
            chk({scen, " R4 cause"},     k, 32'(ecause[k]),   32'(m_ecause[k]));
            chk({scen, " R5 vaddr"},     k, 32'(excva[k]),    32'(m_excva[k]));
            chk({scen, " R7 dbgcause"},  k, 32'(dcause[k]),   32'(m_dcause[k]));
            chk({scen, " R7 dbgepc"},    k, 32'(depc_dbg[k]), 32'(m_depc_dbg[k]));
            chk({scen, " R7 dbgeps"},    k, 32'(deps[k]),     32'(m_deps[k]));
            chk({scen, " R4/R8 ps"},     k, 32'(ps_o[k]),     32'(m_ps[k]));
            chk({scen, " R9 valid"},     k, 32'(vvalid[k]),   32'(m_vvalid));
            chk({scen, " R9 vecid"},     k, 32'(vid[k]),      32'(m_vid[k]));
        end
    endtask

    task automatic model_step();
        logic dbg_take;
        logic gen_take;
        dbg_take = raise_dbg && (lvl < 4'(DL));
        gen_take = raise_gen && !dbg_take;
        m_vvalid = dbg_take || gen_take;
        for (int k = 0; k < 2; k++) begin
            m_vid[k] = 3'd0;
            if (dbg_take) begin
                m_dcause[k]   = cause;
                m_depc_dbg[k] = pc;
                m_deps[k]     = ps;
                m_ps[k]       = {ps[7:5], 1'b1, 4'(DL)};
                m_vid[k]      = 3'd4;
            end else if (gen_take) begin
                m_ecause[k] = cause;
                if (vv) m_excva[k] = va;
                m_ps[k] = ps | 8'h10;
                if (ps[4]) begin
                    m_vid[k] = 3'd3;
                    if (k == 0) m_depc[k] = pc;
                    else        m_epc1[k] = pc;
                end else begin
                    m_epc1[k] = pc;
                    m_vid[k]  = ps[5] ? 3'd1 : 3'd2;
                end
            end
        end
    endtask

    // one raise cycle followed by one quiet cycle, both checked
    task automatic step(input string scen, input logic g, input logic d,
                        input int n, input logic [PSW-1:0] ps_v,
                        input logic vv_v, input logic [3:0] lvl_v);
        @(negedge clk);
        raise_gen = g; raise_dbg = d;
        pc = 16'h1000 + 16'(n * 37); cause = 6'(n + 5);
        va = 16'h8000 ^ 16'(n * 91); vv = vv_v; ps = ps_v; lvl = lvl_v;
        model_step();
        @(negedge clk);
        check_all(scen);
        raise_gen = 1'b0; raise_dbg = 1'b0;
        pc = ~pc; cause = ~cause; va = ~va; vv = 1'b1; ps = ~ps; lvl = 4'd0;
        model_step();
        @(negedge clk);
        check_all("R11 quiet");
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_ps[k] = '0; m_epc1[k] = '0; m_depc[k] = '0; m_excva[k] = '0;
            m_depc_dbg[k] = '0; m_ecause[k] = '0; m_dcause[k] = '0;
            m_deps[k] = '0; m_vid[k] = '0;
        end
        m_vvalid = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;

        // general sweep over excm, um, address-valid
        for (int e = 0; e < 2; e++)
            for (int u = 0; u < 2; u++)
                for (int a = 0; a < 2; a++)
                    step(e ? "R3 gen-double" : "R2 gen-first", 1'b1, 1'b0,
                         e * 4 + u * 2 + a,
                         {2'b10, 1'(u), 1'(e), 4'(a + 1)}, 1'(a), 4'd0);

        // debug alone across every interrupt level
        for (int l = 0; l < 16; l++)
            for (int e = 0; e < 2; e++)
                step((l < DL) ? "R7 dbg" : "R6 dbg-masked", 1'b0, 1'b1,
                     20 + l * 2 + e, {2'b01, 1'(l & 1), 1'(e), 4'(l)}, 1'b0, 4'(l));

        // simultaneous general and debug
        for (int l = 0; l < 16; l++)
            step("R10 both", 1'b1, 1'b1, 60 + l,
                 {2'b00, 1'(l & 1), 1'((l >> 1) & 1), 4'(15 - l)}, 1'(l & 1), 4'(l));

        // quiet cycles with moving data inputs
        for (int q = 0; q < 4; q++)
            step("R11 none", 1'b0, 1'b0, 90 + q, 8'(q * 53), 1'b1, 4'(q));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule